// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block drives the register-saving phase of exception entry for a small 16-bit processor. When the core raises an exception request with a cause code, the block captures the current register state and the stack pointer. Over eight following cycles it issues a fixed pattern of stack writes and instruction-queue refill fetch strobes. It then sets the interrupt mask bits in the condition-code byte and pulses `done`, so the core can resume from the head of its refilled queue.

The first value written is a return address, and the cause decides which one. A hardware interrupt saves the address of the instruction that would have run next. A software-interrupt opcode or an unimplemented-opcode trap saves the address just past the offending opcode. Every later cycle is the same for all causes, except the mask update: only the non-maskable-style cause also sets the X mask. Every push pre-decrements the stack address, and the final stack pointer is reported together with `done`.

Top module: `exc_stack_seq`

## Requirements
- R1: With cause code 2'b00 (X interrupt) or 2'b01 (I interrupt), the first write is a 16-bit word of `pc_next` at address `sp_in`-2. This write appears in the second cycle after the accepting clock edge.
- R2: With cause code 2'b10 (software interrupt), the return word is `opc_addr`+1. With cause code 2'b11 (unimplemented-opcode trap), it is `opc_addr`+2.
- R3: The eight output slots after acceptance follow a fixed order. Slot 1 writes the return word. Slot 2 fetches. Slot 3 writes Y. Slot 4 writes X. Slot 5 fetches. Slot 6 writes the accumulator word. Slot 7 writes the CCR byte. Slot 8 fetches.
- R4: Write addresses are `sp_in`-2, -4, -6, -8 for the four words and `sp_in`-9 for the byte, all modulo 2^16. With `done`, `sp_out` equals `sp_in`-9.
- R5: The accumulator word carries `reg_b` in bits 15:8 and `reg_a` in bits 7:0.
- R6: The CCR write has `mem_word`=0, carries the CCR value from before the mask update in bits 7:0, and has zeros in bits 15:8.
- R7: After the sequence, `ccr_out` equals `ccr_in` with bit 4 (I) set. For cause 2'b00, bit 6 (X) is also set. In every other case bit 6 and all remaining bits are unchanged.
- R8: `done` is high for exactly one cycle, in the slot after the third fetch. `busy` is high from the accepting edge through the `done` cycle and low after it.
- R9: A request raised while `busy` is high is ignored. The writes, fetches, `ccr_out` and `sp_out` of the running sequence are unaffected.
- R10: Each write and each fetch strobe lasts one cycle, and `mem_wr` and `qfetch` are never high in the same cycle.
- R11: After reset, `mem_wr`, `qfetch`, `busy`, `done`, `ccr_out` and `sp_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request, accepted when idle |
| exc_cause | input | 2 | Cause: 00 X int, 01 I int, 10 software int, 11 trap |
| pc_next | input | 16 | Address of the next instruction for interrupts |
| opc_addr | input | 16 | Address of the trapping or software-interrupt opcode |
| reg_y | input | 16 | Y index register |
| reg_x | input | 16 | X index register |
| reg_a | input | 8 | Accumulator A |
| reg_b | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition-code byte |
| sp_in | input | 16 | Stack pointer before entry |
| mem_wr | output | 1 | Stack write strobe |
| mem_word | output | 1 | 1 = 16-bit write, 0 = byte write |
| mem_addr | output | 16 | Write address (pre-decremented) |
| mem_wdata | output | 16 | Write data |
| qfetch | output | 1 | Program-word fetch strobe for queue refill |
| ccr_out | output | 8 | Condition-code byte with updated masks |
| sp_out | output | 16 | Stack pointer after the frame |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 16-bit addresses, 8-bit bytes, the X mask at bit 6, the I mask at bit 4, and opcode lengths of 1 and 2. With a 16-bit address, a stack base near zero is easy to reach, so the directed cases cover the frame wrapping below address zero. They also cover a CCR with the X mask already clear, so the X cause visibly changes bit 6 while the other causes leave it alone. Random register values and all four causes vary every field of the frame. A second request issued mid-sequence checks that the running frame is not disturbed.

// File: rtl/exc_stack_pkg.sv
package exc_stack_pkg;

  typedef enum logic [1:0] {
    CAUSE_XINT = 2'd0,
    CAUSE_IINT = 2'd1,
    CAUSE_SWI  = 2'd2,
    CAUSE_TRAP = 2'd3
  } cause_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_RTN, ST_F1, ST_PY, ST_PX,
    ST_F2, ST_PBA, ST_PCCR, ST_F3, ST_DONE
  } step_t;

  function automatic step_t step_after(step_t s);
    case (s)
      ST_LOAD: return ST_RTN;
      ST_RTN:  return ST_F1;
      ST_F1:   return ST_PY;
      ST_PY:   return ST_PX;
      ST_PX:   return ST_F2;
      ST_F2:   return ST_PBA;
      ST_PBA:  return ST_PCCR;
      ST_PCCR: return ST_F3;
      ST_F3:   return ST_DONE;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_stack_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req,
  output logic  accept,
  output step_t step_nxt
);

  step_t step_q;

  always_comb begin
    accept = req && (step_q == ST_IDLE);
    if (accept)
      step_nxt = ST_LOAD;
    else if (step_q == ST_IDLE)
      step_nxt = ST_IDLE;
    else
      step_nxt = step_after(step_q);
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_nxt;
  end

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr
  import exc_stack_pkg::*;
#(
  parameter int AW       = 16,
  parameter int SWI_LEN  = 1,
  parameter int TRAP_LEN = 2
) (
  input  cause_t        cause,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] opc_addr,
  output logic [AW-1:0] ret
);

  always_comb begin
    case (cause)
      CAUSE_SWI:  ret = opc_addr + AW'(SWI_LEN);
      CAUSE_TRAP: ret = opc_addr + AW'(TRAP_LEN);
      default:    ret = pc_next;
    endcase
  end

endmodule

// File: rtl/exc_ccr_mask.sv
module exc_ccr_mask
  import exc_stack_pkg::*;
#(
  parameter int CW    = 8,
  parameter int X_BIT = 6,
  parameter int I_BIT = 4
) (
  input  cause_t        cause,
  input  logic [CW-1:0] ccr,
  output logic [CW-1:0] masked
);

  logic [CW-1:0] set_bits;

  always_comb begin
    set_bits        = '0;
    set_bits[I_BIT] = 1'b1;
    if (cause == CAUSE_XINT) set_bits[X_BIT] = 1'b1;
    masked = ccr | set_bits;
  end

endmodule

// File: rtl/exc_push_dec.sv
module exc_push_dec
  import exc_stack_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int CW = 8
) (
  input  step_t           st,
  input  logic [AW-1:0]   ret,
  input  logic [2*BW-1:0] y,
  input  logic [2*BW-1:0] x,
  input  logic [BW-1:0]   a,
  input  logic [BW-1:0]   b,
  input  logic [CW-1:0]   ccr,
  input  logic [AW-1:0]   sp,
  output logic            wr,
  output logic            word,
  output logic [AW-1:0]   addr,
  output logic [2*BW-1:0] data,
  output logic            fetch,
  output logic            mask_upd
);

  localparam int WB = 2;

  always_comb begin
    wr       = 1'b0;
    word     = 1'b0;
    addr     = '0;
    data     = '0;
    fetch    = 1'b0;
    mask_upd = 1'b0;
    case (st)
      ST_RTN: begin
        wr = 1'b1; word = 1'b1; addr = sp - AW'(WB);
        data = (2*BW)'(ret);
      end
      ST_PY: begin
        wr = 1'b1; word = 1'b1; addr = sp - AW'(2*WB); data = y;
      end
      ST_PX: begin
        wr = 1'b1; word = 1'b1; addr = sp - AW'(3*WB); data = x;
      end
      ST_PBA: begin
        wr = 1'b1; word = 1'b1; addr = sp - AW'(4*WB); data = {b, a};
      end
      ST_PCCR: begin
        wr = 1'b1; word = 1'b0; addr = sp - AW'(4*WB + 1);
        data = {{(2*BW-CW){1'b0}}, ccr};
        mask_upd = 1'b1;
      end
      ST_F1, ST_F2, ST_F3: fetch = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq
  import exc_stack_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BW       = 8,
  parameter int CW       = 8,
  parameter int X_BIT    = 6,
  parameter int I_BIT    = 4,
  parameter int SWI_LEN  = 1,
  parameter int TRAP_LEN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_req,
  input  logic [1:0]      exc_cause,
  input  logic [AW-1:0]   pc_next,
  input  logic [AW-1:0]   opc_addr,
  input  logic [2*BW-1:0] reg_y,
  input  logic [2*BW-1:0] reg_x,
  input  logic [BW-1:0]   reg_a,
  input  logic [BW-1:0]   reg_b,
  input  logic [CW-1:0]   ccr_in,
  input  logic [AW-1:0]   sp_in,
  output logic            mem_wr,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [2*BW-1:0] mem_wdata,
  output logic            qfetch,
  output logic [CW-1:0]   ccr_out,
  output logic [AW-1:0]   sp_out,
  output logic            busy,
  output logic            done
);

  localparam int FRAME_BYTES = 4 * 2 + 1;

  logic            accept;
  step_t           step_nxt;
  cause_t          cause_in;
  logic [AW-1:0]   ret_in;
  cause_t          cause_q;
  logic [AW-1:0]   ret_q, sp_q;
  logic [2*BW-1:0] y_q, x_q;
  logic [BW-1:0]   a_q, b_q;
  logic [CW-1:0]   ccr_q, ccr_masked;
  logic            d_wr, d_word, d_fetch, d_mask;
  logic [AW-1:0]   d_addr;
  logic [2*BW-1:0] d_data;

  assign cause_in = cause_t'(exc_cause);

  exc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (exc_req),
    .accept   (accept),
    .step_nxt (step_nxt)
  );

  exc_ret_addr #(.AW(AW), .SWI_LEN(SWI_LEN), .TRAP_LEN(TRAP_LEN)) u_ret (
    .cause    (cause_in),
    .pc_next  (pc_next),
    .opc_addr (opc_addr),
    .ret      (ret_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= CAUSE_XINT;
      ret_q <= '0; sp_q <= '0; y_q <= '0; x_q <= '0;
      a_q <= '0; b_q <= '0; ccr_q <= '0;
    end else if (accept) begin
      cause_q <= cause_in;
      ret_q   <= ret_in;
      sp_q    <= sp_in;
      y_q     <= reg_y;
      x_q     <= reg_x;
      a_q     <= reg_a;
      b_q     <= reg_b;
      ccr_q   <= ccr_in;
    end
  end

  exc_push_dec #(.AW(AW), .BW(BW), .CW(CW)) u_dec (
    .st       (step_nxt),
    .ret      (ret_q),
    .y        (y_q),
    .x        (x_q),
    .a        (a_q),
    .b        (b_q),
    .ccr      (ccr_q),
    .sp       (sp_q),
    .wr       (d_wr),
    .word     (d_word),
    .addr     (d_addr),
    .data     (d_data),
    .fetch    (d_fetch),
    .mask_upd (d_mask)
  );

  exc_ccr_mask #(.CW(CW), .X_BIT(X_BIT), .I_BIT(I_BIT)) u_mask (
    .cause  (cause_q),
    .ccr    (ccr_q),
    .masked (ccr_masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr    <= 1'b0;
      mem_word  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      qfetch    <= 1'b0;
      ccr_out   <= '0;
      sp_out    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_wr    <= d_wr;
      mem_word  <= d_word;
      mem_addr  <= d_addr;
      mem_wdata <= d_data;
      qfetch    <= d_fetch;
      busy      <= (step_nxt != ST_IDLE);
      done      <= (step_nxt == ST_DONE);
      if (accept)      ccr_out <= ccr_in;
      else if (d_mask) ccr_out <= ccr_masked;
      if (step_nxt == ST_DONE) sp_out <= sp_q - AW'(FRAME_BYTES);
    end
  end

endmodule

// File: rtl/exc_stack_seq_chk.sv
module exc_stack_seq_chk #(
  parameter int AW    = 16,
  parameter int BW    = 8,
  parameter int CW    = 8,
  parameter int I_BIT = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_wr,
  input logic            mem_word,
  input logic [AW-1:0]   mem_addr,
  input logic [2*BW-1:0] mem_wdata,
  input logic            qfetch,
  input logic [CW-1:0]   ccr_out,
  input logic            busy,
  input logic            done
);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && qfetch));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_busy_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);

  a_r7_i_mask_set: assert property (@(posedge clk) disable iff (rst)
    done |-> ccr_out[I_BIT]);

  a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
    mem_wr && mem_word && $past(mem_wr) && $past(mem_word)
      |-> mem_addr == AW'($past(mem_addr) - AW'(2)));

  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    mem_wr && !mem_word |-> mem_wdata[2*BW-1:BW] == '0);

endmodule

bind exc_stack_seq exc_stack_seq_chk #(.AW(AW), .BW(BW), .CW(CW), .I_BIT(I_BIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_wr    (mem_wr),
  .mem_word  (mem_word),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .qfetch    (qfetch),
  .ccr_out   (ccr_out),
  .busy      (busy),
  .done      (done)
);

// File: tb/exc_stack_seq_tb.sv
`timescale 1ns/1ps
module exc_stack_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [1:0]  exc_cause = '0;
  logic [15:0] pc_next = '0, opc_addr = '0, reg_y = '0, reg_x = '0, sp_in = '0;
  logic [7:0]  reg_a = '0, reg_b = '0, ccr_in = '0;
  logic        mem_wr, mem_word, qfetch, busy, done;
  logic [15:0] mem_addr, mem_wdata, sp_out;
  logic [7:0]  ccr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  exc_stack_seq u_dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
    .pc_next(pc_next), .opc_addr(opc_addr), .reg_y(reg_y), .reg_x(reg_x),
    .reg_a(reg_a), .reg_b(reg_b), .ccr_in(ccr_in), .sp_in(sp_in),
    .mem_wr(mem_wr), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .qfetch(qfetch), .ccr_out(ccr_out),
    .sp_out(sp_out), .busy(busy), .done(done)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_ret(logic [1:0] c, logic [15:0] pc, logic [15:0] op);
    if (c == 2'b10) return op + 16'd1;
    if (c == 2'b11) return op + 16'd2;
    return pc;
  endfunction

  function automatic logic [7:0] exp_ccr(logic [1:0] c, logic [7:0] cc);
    logic [7:0] r;
    r = cc | 8'h10;
    if (c == 2'b00) r = r | 8'h40;
    return r;
  endfunction

  task automatic run_case(logic [1:0] c, logic [15:0] pc, logic [15:0] op,
                          logic [15:0] y, logic [15:0] x, logic [7:0] a,
                          logic [7:0] b, logic [7:0] cc, logic [15:0] sp,
                          bit intrude);
    logic [15:0] ret;
    ret = exp_ret(c, pc, op);
    @(negedge clk);
    exc_req = 1'b1; exc_cause = c; pc_next = pc; opc_addr = op;
    reg_y = y; reg_x = x; reg_a = a; reg_b = b; ccr_in = cc; sp_in = sp;
    @(posedge clk);
    @(negedge clk);
    exc_req = 1'b0;
    check("R8 busy after accept", {31'd0, busy}, 32'd1);
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (intrude && k == 3) begin
        exc_req = 1'b1; exc_cause = ~c; pc_next = ~pc; opc_addr = ~op;
        reg_y = ~y; reg_x = ~x; reg_a = ~a; reg_b = ~b; ccr_in = ~cc; sp_in = ~sp;
      end
      if (intrude && k == 7) exc_req = 1'b0;
      case (k)
        1: begin
          check("R3 slot1 write", {31'd0, mem_wr}, 32'd1);
          check(c[1] ? "R2 return word" : "R1 return word", {16'd0, mem_wdata}, {16'd0, ret});
          check("R1 return addr/size", {15'd0, mem_word, mem_addr}, {15'd0, 1'b1, sp - 16'd2});
        end
        2, 5, 8: begin
          check("R10 fetch only", {30'd0, qfetch, mem_wr}, 32'd2);
        end
        3: begin
          check("R3 push Y", {15'd0, mem_wr, mem_wdata}, {15'd0, 1'b1, y});
          check("R4 Y addr", {15'd0, mem_word, mem_addr}, {15'd0, 1'b1, sp - 16'd4});
          check("R10 no fetch", {31'd0, qfetch}, 32'd0);
        end
        4: begin
          check("R3 push X", {15'd0, mem_wr, mem_wdata}, {15'd0, 1'b1, x});
          check("R4 X addr", {15'd0, mem_word, mem_addr}, {15'd0, 1'b1, sp - 16'd6});
        end
        6: begin
          check("R5 B:A word", {15'd0, mem_wr, mem_wdata}, {15'd0, 1'b1, b, a});
          check("R4 B:A addr", {15'd0, mem_word, mem_addr}, {15'd0, 1'b1, sp - 16'd8});
        end
        7: begin
          check("R6 CCR byte", {15'd0, mem_wr, mem_wdata}, {15'd0, 1'b1, 8'h00, cc});
          check("R6 byte size/addr", {15'd0, mem_word, mem_addr}, {15'd0, 1'b0, sp - 16'd9});
        end
        9: begin
          check("R8 done slot", {29'd0, done, busy, mem_wr | qfetch}, {29'd0, 1'b1, 1'b1, 1'b0});
          check("R7 ccr masks", {24'd0, ccr_out}, {24'd0, exp_ccr(c, cc)});
          check("R4 final sp", {16'd0, sp_out}, {16'd0, sp - 16'd9});
        end
        10: begin
          check("R8 idle after done", {29'd0, done, busy, mem_wr | qfetch}, 32'd0);
          if (intrude) check("R9 intrusion ignored", {16'd0, sp_out}, {16'd0, sp - 16'd9});
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset strobes", {27'd0, mem_wr, qfetch, busy, done, 1'b0}, 32'd0);
    check("R11 reset ccr/sp", {8'd0, ccr_out, sp_out}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // directed corner cases
    run_case(2'b00, 16'h1234, 16'h1230, 16'hAAAA, 16'h5555, 8'h11, 8'h22, 8'h00, 16'h3000, 1'b0);
    run_case(2'b01, 16'h4000, 16'h3FFE, 16'h0102, 16'h0304, 8'hA5, 8'h5A, 8'h0F, 16'h0004, 1'b0);
    run_case(2'b10, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 8'hFF, 8'h00, 8'hAF, 16'h8000, 1'b0);
    run_case(2'b11, 16'h7777, 16'hFFFE, 16'h1357, 16'h2468, 8'h01, 8'h80, 8'h80, 16'h0000, 1'b0);
    run_case(2'b01, 16'hBEEF, 16'h0100, 16'hC0DE, 16'hF00D, 8'h3C, 8'hC3, 8'h00, 16'h2000, 1'b1);
    // constrained random
    for (int i = 0; i < 40; i++) begin
      run_case(2'($urandom_range(3)), 16'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
               16'($urandom), (i % 5) == 0);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule